// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block walks one DMA channel through a block of bus transfers. Software-side logic loads a control word, then starts the channel with an initial read address, an initial write address and a transfer count. While work remains, the sequencer raises a request. Each cycle in which the bus side grants that request, the current address pair is issued and both addresses are then advanced. Each address either steps by the element size or stays fixed. Either address can also be confined to a naturally aligned ring.

The write data lane is the read data after an optional byte reorder that depends on the element size. The sequencer counts issued pairs that have not yet completed. Busy stays high until the count is used up and every issued pair has retired. An abort stops further issue and lets outstanding pairs drain before busy drops. Clearing the enable freezes the channel where it stands, without ending it.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset the control word has enable on, read stepping on, write stepping off, 32-bit elements, no ring and no byte reorder. Busy and request are low.
- R2: A start pulse loads both addresses and the count when enable is on, the channel is idle and the count is non-zero. Busy is high from the next cycle. A start is ignored when the count is zero, when the channel is busy or when enable is off.
- R3: While the request is high, `rd_addr` and `wr_addr` show the pair issued by a grant. After the grant, a stepping side moves by 1, 2 or 4 bytes for size codes 0, 1 and 2. With no grant, the addresses hold.
- R4: A side whose stepping is off keeps the same address for every transfer.
- R5: A ring field n of 1 to 15 keeps address bits above n-1 fixed, so the low n bits wrap on a 2^n byte boundary. A ring field of 0 disables the ring. The ring-select bit applies the ring to the write address when 1 and to the read address when 0.
- R6: With byte reorder on, `wr_data` exchanges the two bytes inside each 16-bit half for size 1 and reverses all four bytes for size 2. For size 0 it equals `rd_data`. With byte reorder off, `wr_data` always equals `rd_data`.
- R7: Each grant uses up one transfer. The request drops after the last one. Busy stays high until every issued pair has been retired through `retire`.
- R8: With enable off, the request is low, grants have no effect and addresses hold. Busy stays high. Setting enable again resumes at the next address.
- R9: An abort pulse drops the request in the same cycle and ends the sequence. Busy clears only when no issued pair remains outstanding.
- R10: At most PEND_MAX issued pairs (default 2) may be outstanding. The request is low while that many are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Load the control fields below |
| cfg_en | input | 1 | Channel enable |
| cfg_rd_inc | input | 1 | Read address stepping on |
| cfg_wr_inc | input | 1 | Write address stepping on |
| cfg_size | input | 2 | Element size: 0 byte, 1 halfword, 2 word |
| cfg_ring_bits | input | 4 | Ring size as log2 bytes, 0 = off |
| cfg_ring_wr | input | 1 | Ring applies to write (1) or read (0) side |
| cfg_swap | input | 1 | Byte reorder on |
| start | input | 1 | Start pulse |
| start_rd_addr | input | ADDR_W | Initial read address |
| start_wr_addr | input | ADDR_W | Initial write address |
| start_count | input | CNT_W | Number of transfers |
| grant | input | 1 | Bus accepts the current pair |
| retire | input | 1 | One issued pair has completed |
| abort | input | 1 | Abort pulse |
| rd_data | input | 32 | Data read from the source |
| req | output | 1 | Channel wants to issue |
| busy | output | 1 | Sequence or outstanding pairs active |
| rd_addr | output | ADDR_W | Current read address |
| wr_addr | output | ADDR_W | Current write address |
| wr_data | output | 32 | Reordered data for the write |

## Verification
The assertions assume that `retire` is pulsed only while at least one issued pair is outstanding. They also assume that `ADDR_W` is wider than the largest ring field. The bench keeps to this: every retire follows a grant it has already made, and it never retires more pairs than it issued. Start pulses land while the channel is idle, except in the one case that checks that a start during a busy sequence is ignored.

// File: rtl/dma_seq_pkg.sv
// Shared types for the DMA channel address sequencer.
// Assumes: size codes above 2 are not used by software.
package dma_seq_pkg;

    typedef enum logic [1:0] {
        ELEM_B8  = 2'd0,
        ELEM_B16 = 2'd1,
        ELEM_B32 = 2'd2
    } elem_size_e;

    typedef struct packed {
        logic       en;
        logic       rd_inc;
        logic       wr_inc;
        elem_size_e size;
        logic [3:0] ring_bits;
        logic       ring_wr;
        logic       swap;
    } chan_ctrl_t;

    localparam chan_ctrl_t CTRL_RESET = '{
        en: 1'b1, rd_inc: 1'b1, wr_inc: 1'b0, size: ELEM_B32,
        ring_bits: 4'd0, ring_wr: 1'b0, swap: 1'b0
    };

    // Byte stride for one element; the reserved code 3 behaves as a word
    function automatic logic [2:0] elem_stride(input elem_size_e s);
        case (s)
            ELEM_B8:  return 3'd1;
            ELEM_B16: return 3'd2;
            default:  return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_step.sv
// Computes the next address of one side of the channel.
// The step is the element stride, or zero when stepping is off. When the ring
// is active, only the low ring_i bits may change.
// Assumes: ADDR_W > 15.
module dma_addr_step
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              inc_i,
    input  elem_size_e        size_i,
    input  logic [3:0]        ring_i,
    input  logic              wrap_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] sum;

    // Merge the fixed upper part with the advanced low part
    always_comb begin
        step   = inc_i ? ADDR_W'(elem_stride(size_i)) : '0;
        mask   = (wrap_i && ring_i != 4'd0)
               ? ((ADDR_W'(1) << ring_i) - ADDR_W'(1)) : '1;
        sum    = addr_i + step;
        addr_o = (addr_i & ~mask) | (sum & mask);
    end

endmodule

// File: rtl/dma_lane_swap.sv
// Reorders the bytes of the data lane according to element size.
// Assumes: a 32-bit lane. Halfword mode swaps within each 16-bit half.
module dma_lane_swap
    import dma_seq_pkg::*;
(
    input  logic [31:0] din,
    input  logic        swap_i,
    input  elem_size_e  size_i,
    output logic [31:0] dout
);

    // Pick the byte order for the configured element size
    always_comb begin
        if (!swap_i || size_i == ELEM_B8)
            dout = din;
        else if (size_i == ELEM_B16)
            dout = {din[23:16], din[31:24], din[7:0], din[15:8]};
        else
            dout = {din[7:0], din[15:8], din[23:16], din[31:24]};
    end

    // Byte elements and disabled reorder leave the lane untouched
    always_comb begin
        if (!swap_i || size_i == ELEM_B8)
            AST_BYTE_PASS: assert (dout == din); // R6
    end

endmodule

// File: rtl/dma_xfer_ctrl.sv
// Transfer bookkeeping for one channel: remaining count, running flag,
// count of outstanding pairs, request and busy.
// Assumes: retire is pulsed only while a pair is outstanding.
module dma_xfer_ctrl #(
    parameter int CNT_W    = 16,
    parameter int PEND_MAX = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             start,
    input  logic [CNT_W-1:0] count_i,
    input  logic             abort,
    input  logic             grant,
    input  logic             retire,
    output logic             req,
    output logic             issue,
    output logic             accept,
    output logic             busy
);

    localparam int PEND_W = $clog2(PEND_MAX + 1);

    logic [CNT_W-1:0]  remain;
    logic              running;
    logic [PEND_W-1:0] pend;

    // Request while running, enabled, not aborting and below the pending cap
    always_comb begin
        req    = running && en && !abort && (pend != PEND_W'(PEND_MAX));
        issue  = req && grant;
        busy   = running || (pend != '0);
        accept = start && en && !busy && (count_i != '0);
    end

    // Running flag and remaining count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            remain  <= '0;
        end else if (abort) begin
            running <= 1'b0;
        end else if (accept) begin
            running <= 1'b1;
            remain  <= count_i;
        end else if (issue) begin
            remain  <= remain - CNT_W'(1);
            if (remain == CNT_W'(1))
                running <= 1'b0;
        end
    end

    // Outstanding pair counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= '0;
        else
            pend <= pend + PEND_W'(issue) - PEND_W'(retire);
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !abort) |=> remain == $past(remain) - CNT_W'(1)); // R7
    AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !req); // R8
    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !req); // R9
    AST_PEND_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= PEND_W'(PEND_MAX)); // R10
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !issue) |=> remain == $past(remain)); // R2

endmodule

// File: rtl/dma_addr_seq.sv
// One DMA channel's address sequencer: control word, read and write address
// registers with their step logic, data lane reorder and transfer control.
// Assumes: start is used only to begin a new sequence on an idle channel.
module dma_addr_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 16,
    parameter int PEND_MAX = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_en,
    input  logic              cfg_rd_inc,
    input  logic              cfg_wr_inc,
    input  logic [1:0]        cfg_size,
    input  logic [3:0]        cfg_ring_bits,
    input  logic              cfg_ring_wr,
    input  logic              cfg_swap,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_rd_addr,
    input  logic [ADDR_W-1:0] start_wr_addr,
    input  logic [CNT_W-1:0]  start_count,
    input  logic              grant,
    input  logic              retire,
    input  logic              abort,
    input  logic [31:0]       rd_data,
    output logic              req,
    output logic              busy,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data
);

    localparam int SIDES = 2;

    chan_ctrl_t        ctrl;
    logic              issue;
    logic              accept;
    logic [ADDR_W-1:0] cur  [SIDES];
    logic [ADDR_W-1:0] nxt  [SIDES];
    logic [ADDR_W-1:0] init [SIDES];
    logic [SIDES-1:0]  inc_sel;
    logic [SIDES-1:0]  wrap_sel;
    logic [ADDR_W-1:0] ring_mask;

    // Control word register
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= CTRL_RESET;
        else if (cfg_wr)
            ctrl <= '{en: cfg_en, rd_inc: cfg_rd_inc, wr_inc: cfg_wr_inc,
                      size: elem_size_e'(cfg_size), ring_bits: cfg_ring_bits,
                      ring_wr: cfg_ring_wr, swap: cfg_swap};
    end

    // Side 0 is read, side 1 is write
    always_comb begin
        inc_sel   = {ctrl.wr_inc, ctrl.rd_inc};
        wrap_sel  = {ctrl.ring_wr, !ctrl.ring_wr};
        init[0]   = start_rd_addr;
        init[1]   = start_wr_addr;
        ring_mask = (ADDR_W'(1) << ctrl.ring_bits) - ADDR_W'(1);
    end

    dma_xfer_ctrl #(
        .CNT_W    (CNT_W),
        .PEND_MAX (PEND_MAX)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctrl.en),
        .start   (start),
        .count_i (start_count),
        .abort   (abort),
        .grant   (grant),
        .retire  (retire),
        .req     (req),
        .issue   (issue),
        .accept  (accept),
        .busy    (busy)
    );

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        dma_addr_step #(
            .ADDR_W (ADDR_W)
        ) u_step (
            .addr_i (cur[s]),
            .inc_i  (inc_sel[s]),
            .size_i (ctrl.size),
            .ring_i (ctrl.ring_bits),
            .wrap_i (wrap_sel[s]),
            .addr_o (nxt[s])
        );

        // Address register: load on start, advance on issue
        always_ff @(posedge clk) begin
            if (!rst_n)
                cur[s] <= '0;
            else if (accept)
                cur[s] <= init[s];
            else if (issue)
                cur[s] <= nxt[s];
        end
    end

    assign rd_addr = cur[0];
    assign wr_addr = cur[1];

    dma_lane_swap u_swap (
        .din    (rd_data),
        .swap_i (ctrl.swap),
        .size_i (ctrl.size),
        .dout   (wr_data)
    );

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !ctrl.rd_inc && !cfg_wr) |=> rd_addr == $past(rd_addr)); // R4
    AST_WR_RING_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && ctrl.ring_wr && ctrl.ring_bits != 4'd0)
        |=> (wr_addr & ~$past(ring_mask)) == ($past(wr_addr) & ~$past(ring_mask))); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue && !accept) |=> $stable(rd_addr) && $stable(wr_addr)); // R3

endmodule

// File: tb/dma_addr_seq_tb.sv
module dma_addr_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 0, cfg_en = 0, cfg_rd_inc = 0, cfg_wr_inc = 0;
    logic [1:0]  cfg_size = 0;
    logic [3:0]  cfg_ring_bits = 0;
    logic        cfg_ring_wr = 0, cfg_swap = 0;
    logic        start = 0;
    logic [31:0] start_rd_addr = 0, start_wr_addr = 0;
    logic [15:0] start_count = 0;
    logic        grant = 0, retire = 0, abort = 0;
    logic [31:0] rd_data = 0;
    logic        req, busy;
    logic [31:0] rd_addr, wr_addr, wr_data;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dma_addr_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
        .cfg_rd_inc(cfg_rd_inc), .cfg_wr_inc(cfg_wr_inc), .cfg_size(cfg_size),
        .cfg_ring_bits(cfg_ring_bits), .cfg_ring_wr(cfg_ring_wr), .cfg_swap(cfg_swap),
        .start(start), .start_rd_addr(start_rd_addr), .start_wr_addr(start_wr_addr),
        .start_count(start_count), .grant(grant), .retire(retire), .abort(abort),
        .rd_data(rd_data), .req(req), .busy(busy), .rd_addr(rd_addr),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic en, ri, wi, input logic [1:0] sz,
                           input logic [3:0] ring, input logic rw, sw);
        @(negedge clk);
        cfg_en = en; cfg_rd_inc = ri; cfg_wr_inc = wi; cfg_size = sz;
        cfg_ring_bits = ring; cfg_ring_wr = rw; cfg_swap = sw; cfg_wr = 1;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic kick(input logic [31:0] ra, wa, input logic [15:0] cnt);
        @(negedge clk);
        start_rd_addr = ra; start_wr_addr = wa; start_count = cnt; start = 1;
        @(negedge clk);
        start = 0;
    endtask

    // One granted transfer followed by its retire
    task automatic xfer(input string tag, input logic [31:0] er, ew);
        @(negedge clk);
        chk({tag, " req"}, 32'(req), 32'd1);
        chk({tag, " rd_addr"}, rd_addr, er);
        chk({tag, " wr_addr"}, wr_addr, ew);
        grant = 1;
        @(negedge clk);
        grant = 0; retire = 1;
        @(negedge clk);
        retire = 0;
    endtask

    task automatic t_reset_defaults();
        chk("R1 busy after reset", 32'(busy), 32'd0);
        chk("R1 req after reset", 32'(req), 32'd0);
        kick(32'h1000, 32'h2000, 16'd3);
        rd_data = 32'hA1B2C3D4;
        #1 chk("R1 no reorder by default", wr_data, 32'hA1B2C3D4);
        xfer("R1 default step 0", 32'h1000, 32'h2000);
        xfer("R1 default step 1", 32'h1004, 32'h2000);
        xfer("R4 write held", 32'h1008, 32'h2000);
        chk("R7 busy ends", 32'(busy), 32'd0);
    endtask

    task automatic t_sizes();
        set_cfg(1, 1, 1, 2'd0, 4'd0, 0, 0);
        kick(32'h0011, 32'h0020, 16'd2);
        xfer("R3 byte step 0", 32'h0011, 32'h0020);
        xfer("R3 byte step 1", 32'h0012, 32'h0021);
        set_cfg(1, 1, 1, 2'd1, 4'd0, 0, 0);
        kick(32'h0100, 32'h0200, 16'd2);
        xfer("R3 half step 0", 32'h0100, 32'h0200);
        xfer("R3 half step 1", 32'h0102, 32'h0202);
        set_cfg(1, 0, 1, 2'd2, 4'd0, 0, 0);
        kick(32'h0300, 32'h0400, 16'd2);
        xfer("R4 read held 0", 32'h0300, 32'h0400);
        xfer("R4 read held 1", 32'h0300, 32'h0404);
    endtask

    task automatic t_ring();
        set_cfg(1, 1, 1, 2'd2, 4'd3, 0, 0);
        kick(32'h1004, 32'h2000, 16'd3);
        xfer("R5 read ring 0", 32'h1004, 32'h2000);
        xfer("R5 read ring 1", 32'h1000, 32'h2004);
        xfer("R5 read ring 2", 32'h1004, 32'h2008);
        set_cfg(1, 1, 1, 2'd2, 4'd4, 1, 0);
        kick(32'h10FC, 32'h30FC, 16'd2);
        xfer("R5 write ring 0", 32'h10FC, 32'h30FC);
        xfer("R5 write ring 1", 32'h1100, 32'h30F0);
    endtask

    task automatic t_swap();
        rd_data = 32'h11223344;
        set_cfg(1, 1, 0, 2'd0, 4'd0, 0, 1);
        #1 chk("R6 byte unchanged", wr_data, 32'h11223344);
        set_cfg(1, 1, 0, 2'd1, 4'd0, 0, 1);
        #1 chk("R6 half swap", wr_data, 32'h22114433);
        set_cfg(1, 1, 0, 2'd2, 4'd0, 0, 1);
        #1 chk("R6 word reverse", wr_data, 32'h44332211);
        set_cfg(1, 1, 0, 2'd2, 4'd0, 0, 0);
        #1 chk("R6 off passes", wr_data, 32'h11223344);
    endtask

    task automatic t_count_busy();
        set_cfg(1, 1, 0, 2'd2, 4'd0, 0, 0);
        kick(32'h0040, 32'h0050, 16'd0);
        chk("R2 zero count ignored", 32'(busy), 32'd0);
        kick(32'h0040, 32'h0050, 16'd2);
        chk("R2 busy after start", 32'(busy), 32'd1);
        kick(32'h0080, 32'h0090, 16'd5);
        chk("R2 start while busy ignored", rd_addr, 32'h0040);
        xfer("R7 first", 32'h0040, 32'h0050);
        @(negedge clk);
        grant = 1;
        @(negedge clk);
        grant = 0;
        chk("R7 req low after last", 32'(req), 32'd0);
        chk("R7 busy while pending", 32'(busy), 32'd1);
        retire = 1;
        @(negedge clk);
        retire = 0;
        chk("R7 busy clears on retire", 32'(busy), 32'd0);
    endtask

    task automatic t_enable();
        set_cfg(1, 1, 0, 2'd2, 4'd0, 0, 0);
        kick(32'h0100, 32'h0200, 16'd3);
        xfer("R8 before pause", 32'h0100, 32'h0200);
        set_cfg(0, 1, 0, 2'd2, 4'd0, 0, 0);
        chk("R8 req low when disabled", 32'(req), 32'd0);
        grant = 1;
        @(negedge clk);
        grant = 0;
        chk("R8 grant ignored", rd_addr, 32'h0104);
        chk("R8 busy held", 32'(busy), 32'd1);
        set_cfg(1, 1, 0, 2'd2, 4'd0, 0, 0);
        xfer("R8 resume 0", 32'h0104, 32'h0200);
        xfer("R8 resume 1", 32'h0108, 32'h0200);
        chk("R8 done", 32'(busy), 32'd0);
        set_cfg(0, 1, 0, 2'd2, 4'd0, 0, 0);
        kick(32'h0500, 32'h0600, 16'd2);
        chk("R2 start ignored when disabled", 32'(busy), 32'd0);
        set_cfg(1, 1, 0, 2'd2, 4'd0, 0, 0);
    endtask

    task automatic t_abort();
        kick(32'h0700, 32'h0800, 16'd5);
        @(negedge clk);
        grant = 1;
        @(negedge clk);
        grant = 0; abort = 1;
        #1 chk("R9 req drops with abort", 32'(req), 32'd0);
        @(negedge clk);
        abort = 0;
        chk("R9 busy while draining", 32'(busy), 32'd1);
        chk("R9 no request after abort", 32'(req), 32'd0);
        retire = 1;
        @(negedge clk);
        retire = 0;
        chk("R9 busy clears after drain", 32'(busy), 32'd0);
    endtask

    task automatic t_pending();
        kick(32'h0900, 32'h0A00, 16'd4);
        @(negedge clk);
        grant = 1;
        @(negedge clk);
        chk("R10 req with one pending", 32'(req), 32'd1);
        @(negedge clk);
        chk("R10 req low at cap", 32'(req), 32'd0);
        @(negedge clk);
        grant = 0;
        chk("R10 no issue at cap", rd_addr, 32'h0908);
        retire = 1;
        @(negedge clk);
        retire = 0;
        chk("R10 req back below cap", 32'(req), 32'd1);
        abort = 1;
        @(negedge clk);
        abort = 0; retire = 1;
        @(negedge clk);
        retire = 0;
        chk("R9 idle after abort", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        t_reset_defaults();
        t_sizes();
        t_ring();
        t_swap();
        t_count_busy();
        t_enable();
        t_abort();
        t_pending();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule